// File: doc/BRIEF.md
# Wait-Mode Bus Clock Divider

This block slows the bus timing of a device while it sits in its low-power wait state. It runs from one constant reference clock and produces two single-cycle enable strobes, one for the P bus timing domain and one for the E bus timing domain. Logic in those domains advances only on cycles where its strobe is high. Both strobes are derived from the same reference and divided by the same ratio.

A 3-bit slow-control field is written through a plain write-enable/data register port, and its value is read back on a separate output. A value n from 1 to 7 selects division by 2^n, so the ratio ranges from 2 to 128. A value of 0 switches the divider off. The divider also stays off whenever the wait-status input is low. When the divider is off, both strobes are high on every reference cycle.

A change of ratio, and any entry into or exit from wait mode, takes effect only when the current division period ends. The counter then restarts from zero, so no bus period is ever cut short. Within a period, the P strobe fires on its first cycle and the E strobe fires half a period later.

Top module: `slow_clk_div`

## Requirements
- R1: While rst_ni is low and directly after reset, the control field reads 0 and both p_stb_o and e_stb_o are high on every cycle.
- R2: A cycle with reg_we_i high stores reg_wdata_i[2:0] into the control field. The stored value appears on reg_rdata_o from the next cycle on and is held while reg_we_i is low.
- R3: With wait_i high and the control field at 0, both strobes are high on every cycle.
- R4: With wait_i low, both strobes are high on every cycle whatever value the control field holds.
- R5: With wait_i high and the control field at n (1..7), p_stb_o is high exactly once every 2^n cycles.
- R6: e_stb_o has the same period as p_stb_o. It is high 2^(n-1) cycles after each p_stb_o pulse when n is 1 or more, and coincides with p_stb_o when the divider is off.
- R7: A write that changes the ratio in mid-period does not alter the current period, which completes at its old length. The new ratio governs the period that follows.
- R8: A change on wait_i takes effect at the next period boundary. The next period then starts with a p_stb_o pulse and has the newly selected length.
- R9: When the divider is on, each strobe is a single-cycle pulse and p_stb_o and e_stb_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Constant reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wait_i | input | 1 | High while the device is in wait mode |
| reg_we_i | input | 1 | Control field write enable |
| reg_wdata_i | input | 3 | Control field write data: 0 = off, n = divide by 2^n |
| reg_rdata_o | output | 3 | Current control field value |
| p_stb_o | output | 1 | P-domain bus enable strobe |
| e_stb_o | output | 1 | E-domain bus enable strobe |

## Verification
Some properties are checked by the assertions on every cycle: the active ratio stays stable between period boundaries, each boundary follows the wait input and control field, a P pulse opens every period, strobes are single-cycle when dividing, the E and P strobes never overlap, and register writes land. The exact period length for each of the seven ratios, and the half-period position of the E strobe, can only be shown by the bench scenarios that measure the gaps between pulses. The same applies to the full old-length period that follows a mid-period ratio change or a wait-mode exit.

// File: rtl/slow_div_pkg.sv
package slow_div_pkg;
  localparam int CTRL_W = 3;
  localparam int MAX_SHIFT = (1 << CTRL_W) - 1;
  localparam int CNT_W = MAX_SHIFT;

  typedef logic [CTRL_W-1:0] ratio_t;
endpackage

// File: rtl/slow_ctrl_reg.sv
module slow_ctrl_reg #(
  parameter int CTRL_W = slow_div_pkg::CTRL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= wdata_i;
  end

  assign ctrl_o = ctrl_q;

  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ctrl_o == $past(wdata_i));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctrl_o));
endmodule

// File: rtl/slow_ratio_sel.sv
module slow_ratio_sel #(
  parameter int CTRL_W = slow_div_pkg::CTRL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wait_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              boundary_i,
  output logic [CTRL_W-1:0] act_o
);
  logic [CTRL_W-1:0] req;
  logic [CTRL_W-1:0] act_q;

  // divider bypassed outside wait mode
  always_comb req = wait_i ? ctrl_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         act_q <= '0;
    else if (boundary_i) act_q <= req;
  end

  assign act_o = act_q;

  a_r7_hold_mid_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_i |=> $stable(act_o));
  a_r4_bypass_off_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && !wait_i) |=> act_o == '0);
  a_r8_take_ctrl_in_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && wait_i) |=> act_o == $past(ctrl_i));
endmodule

// File: rtl/slow_div_cnt.sv
module slow_div_cnt #(
  parameter int CTRL_W = slow_div_pkg::CTRL_W,
  localparam int CNT_W = (1 << CTRL_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] act_i,
  output logic              boundary_o,
  output logic              p_stb_o,
  output logic              e_stb_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val;
  logic [CNT_W-1:0] half_val;

  always_comb begin
    last_val = {CNT_W{1'b1}} >> (CTRL_W'(CNT_W) - act_i);
    half_val = (act_i == '0) ? '0 : (CNT_W'(1) << (act_i - CTRL_W'(1)));
  end

  assign boundary_o = (cnt_q == last_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (boundary_o) cnt_q <= '0;
    else                 cnt_q <= cnt_q + CNT_W'(1);
  end

  assign p_stb_o = (cnt_q == '0);
  assign e_stb_o = (cnt_q == half_val);

  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_o |=> p_stb_o);
  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_stb_o && act_i != '0) |=> !p_stb_o);
  a_r9_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_stb_o && act_i != '0) |-> !p_stb_o);
  a_r3_off_every_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == '0) |-> (p_stb_o && e_stb_o && boundary_o));
endmodule

// File: rtl/slow_clk_div.sv
module slow_clk_div #(
  parameter int CTRL_W = slow_div_pkg::CTRL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wait_i,
  input  logic              reg_we_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  output logic [CTRL_W-1:0] reg_rdata_o,
  output logic              p_stb_o,
  output logic              e_stb_o
);
  logic [CTRL_W-1:0] ctrl;
  logic [CTRL_W-1:0] act;
  logic              boundary;

  slow_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .ctrl_o  (ctrl)
  );

  slow_ratio_sel #(.CTRL_W(CTRL_W)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wait_i     (wait_i),
    .ctrl_i     (ctrl),
    .boundary_i (boundary),
    .act_o      (act)
  );

  slow_div_cnt #(.CTRL_W(CTRL_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .boundary_o (boundary),
    .p_stb_o    (p_stb_o),
    .e_stb_o    (e_stb_o)
  );

  assign reg_rdata_o = ctrl;

  a_r1_reset_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (reg_rdata_o == '0 && p_stb_o && e_stb_o));
endmodule

// File: tb/slow_clk_div_bench.sv
`timescale 1ns/1ps
module slow_clk_div_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wait_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [2:0] reg_wdata_i = '0;
  logic [2:0] reg_rdata_o;
  logic       p_stb_o;
  logic       e_stb_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  slow_clk_div u_slow_clk_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wait_i      (wait_i),
    .reg_we_i    (reg_we_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .p_stb_o     (p_stb_o),
    .e_stb_o     (e_stb_o)
  );

  // {wait, ctrl}, expected P period, expected E offset
  localparam int N_VEC = 9;
  localparam logic [3:0] VEC_CFG [N_VEC] = '{4'b0101, 4'b1000, 4'b1001, 4'b1010,
                                             4'b1011, 4'b1100, 4'b1110, 4'b1111, 4'b0111};
  localparam int VEC_PER  [N_VEC] = '{1, 1, 2, 4, 8, 16, 64, 128, 1};
  localparam int VEC_EOFF [N_VEC] = '{0, 0, 1, 2, 4, 8, 32, 64, 0};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [2:0] v);
    reg_we_i = 1'b1;
    reg_wdata_i = v;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic sync_p();
    do @(negedge clk_i); while (!p_stb_o);
  endtask

  // starts at a negedge with p_stb_o high
  task automatic gap(output int g, output int eo);
    g = 0;
    eo = e_stb_o ? 0 : -1;
    do begin
      @(negedge clk_i);
      g++;
      if (e_stb_o && eo < 0) eo = g;
      if (e_stb_o && p_stb_o && g > 1) eo = -2;
    end while (!p_stb_o);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int g, eo;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check(reg_rdata_o == 3'd0, "R1 rdata in reset", int'(reg_rdata_o), 0);
    check(p_stb_o && e_stb_o, "R1 strobes in reset", int'({p_stb_o, e_stb_o}), 3);
    rst_ni = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    check(p_stb_o && e_stb_o && reg_rdata_o == 3'd0, "R1 after reset",
          int'({p_stb_o, e_stb_o}), 3);

    // vector table: R2..R6
    for (int i = 0; i < N_VEC; i++) begin
      write_ctrl(VEC_CFG[i][2:0]);
      wait_i = VEC_CFG[i][3];
      check(reg_rdata_o == VEC_CFG[i][2:0], "R2 readback", int'(reg_rdata_o),
            int'(VEC_CFG[i][2:0]));
      sync_p(); sync_p(); sync_p();
      for (int k = 0; k < 2; k++) begin
        gap(g, eo);
        check(g == VEC_PER[i], VEC_CFG[i][3] ? (VEC_CFG[i][2:0] == 0 ? "R3 period" : "R5 period")
              : "R4 period", g, VEC_PER[i]);
        check(eo == VEC_EOFF[i], "R6 e offset", eo, VEC_EOFF[i]);
      end
      check(reg_rdata_o == VEC_CFG[i][2:0], "R2 hold", int'(reg_rdata_o), int'(VEC_CFG[i][2:0]));
    end

    // R9: single-cycle pulses, no overlap at ratio 2
    wait_i = 1'b1;
    write_ctrl(3'd1);
    sync_p(); sync_p(); sync_p();
    begin
      int bad = 0;
      for (int c = 0; c < 16; c++) begin
        if (p_stb_o == e_stb_o) bad++;
        @(negedge clk_i);
      end
      check(bad == 0, "R9 alternating pulses", bad, 0);
    end

    // R7: mid-period change from 128 to 2
    write_ctrl(3'd7);
    sync_p(); sync_p(); sync_p();
    g = 0;
    do begin
      @(negedge clk_i);
      g++;
      if (g == 5) begin reg_we_i = 1'b1; reg_wdata_i = 3'd1; end
      if (g == 6) reg_we_i = 1'b0;
    end while (!p_stb_o);
    check(g == 128, "R7 old period completes", g, 128);
    gap(g, eo);
    check(g == 2, "R7 new ratio next period", g, 2);

    // R8: leave wait mid-period at ratio 8
    write_ctrl(3'd3);
    sync_p(); sync_p(); sync_p();
    g = 0;
    do begin
      @(negedge clk_i);
      g++;
      if (g == 2) wait_i = 1'b0;
    end while (!p_stb_o);
    check(g == 8, "R8 exit keeps period", g, 8);
    gap(g, eo);
    check(g == 1, "R8 bypass after exit", g, 1);

    // R8: enter wait with ratio 8 stored
    @(negedge clk_i);
    wait_i = 1'b1;
    @(negedge clk_i);
    check(p_stb_o == 1'b1, "R8 entry starts with p", int'(p_stb_o), 1);
    gap(g, eo);
    check(g == 8, "R8 entry period", g, 8);
    check(eo == 4, "R6 e offset after entry", eo, 4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule